// File: doc/BRIEF.md
# Remote Terminal Subsystem Word Transfer Handshake

This block sits between the protocol core of a serial-bus remote terminal and the host subsystem that owns the data. It moves 16-bit data words across an 8-bit bidirectional byte highway, sending the high byte first. In a receive message the core presents each validated word. The block then requests a transfer, waits for the host acknowledge and drives both bytes out under a double-pulse strobe. In a transmit message the core asks for the next word. The block requests it from the host and latches the two bytes that the host places on the highway.

A current word counter is visible to the host. It clears when a command is accepted and advances once per transferred word. Acknowledge timeouts depend on direction: the host has 9 cycles on receive transfers and 81 on transmit transfers. A late acknowledge aborts the word, pulses a handshake-failure output and sets a sticky subsystem fault. At the end of a receive message the block checks the outcome. If the transferred word count matches the commanded count and nothing went wrong, a low good-block pulse tells the host that it may use the buffered words.

Top module: `rt_xfer_hshake`

## Requirements
- R1: One cycle after `cmd_valid` is sampled high, `new_cmd_n` is low for exactly one cycle, `dir_tx` equals the sampled `cmd_tx` (0 receive, 1 transmit) and `cwc` is 0. A command preempts any message or transfer in progress.
- R2: In a receive message, `rx_word_valid` makes `req_n` go low in the next cycle. In a transmit message, `tx_word_req` does the same. The request stays low while the block waits for `host_ack_n` low and while the word crosses the highway.
- R3: The first cycle in which `host_ack_n` is sampled low is followed by 1 setup cycle. Then `strobe` is high for 2 cycles, low for 2 cycles and high for 2 cycles. `byte_hi` is 1 throughout the first pulse and 0 throughout the second. In a receive message `hw_oe` is 1 and `hw_out` carries bits 15:8 during the first pulse and bits 7:0 during the second. `hw_oe` is 0 in transmit messages and whenever no receive word is crossing.
- R4: In a transmit message, `hw_in` is captured in the last high cycle of each strobe pulse. `tx_word` = {first byte, second byte}, and `tx_word_valid` is high for the single cycle right after the second pulse.
- R5: `cwc` keeps its value during the second strobe pulse and reads one more (modulo 32) in the cycle after that pulse. It changes only by that step or by clearing to 0.
- R6: `req_n` returns high 2 cycles after the last high cycle of the second strobe pulse. An accepted word therefore holds the request low for (acknowledge delay + 9) cycles, where delay 0 means the acknowledge is seen in the first request cycle.
- R7: In a receive transfer, an acknowledge sampled in any of the first 9 request cycles is accepted. Otherwise `req_n` goes high after exactly 9 low cycles, no strobe is produced, and in that same cycle `hs_fail` is high for one cycle and `ss_fault` becomes 1.
- R8: In a transmit transfer the acknowledge window is 81 cycles, with the same failure behaviour as R7.
- R9: `ss_fault` stays 1 across later commands and messages and clears only on `rst`.
- R10: `good_blk_n` goes low for exactly 3 cycles after `msg_end` is sampled with `msg_ok` = 1, under all of these conditions: the message is a receive message, the number of words transferred equals the command word count (field value 0 means 32), no transfer was in progress, and no timeout or excess word occurred in the message.
- R11: `good_blk_n` stays high if `msg_ok` is 0, the count is short, a timeout occurred, the message is a transmit message, or a new command preempted the message. A preempting command drops `req_n` high and `strobe` low in the next cycle.
- R12: A receive word beyond the commanded count produces no request (`req_n` stays high) and makes the block invalid.
- R13: While and after `rst`: `req_n`, `new_cmd_n` and `good_blk_n` are 1; `strobe`, `hw_oe`, `hs_fail`, `ss_fault`, `tx_word_valid` and `dir_tx` are 0; `cwc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (6 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Core accepted a valid command for this terminal |
| cmd_tx | input | 1 | Direction of that command, 1 = transmit |
| cmd_wc | input | 5 | Word count field of the command, 0 = 32 |
| rx_word_valid | input | 1 | Core holds a validated receive word |
| rx_word | input | 16 | The validated receive word |
| tx_word_req | input | 1 | Core wants the next transmit word |
| msg_end | input | 1 | Core signals end of message |
| msg_ok | input | 1 | Core found the message valid, qualifies `msg_end` |
| host_ack_n | input | 1 | Host acknowledge, active low |
| hw_in | input | 8 | Byte highway as driven by the host |
| new_cmd_n | output | 1 | One-cycle low pulse on command acceptance |
| dir_tx | output | 1 | Current direction, 1 = transmit |
| req_n | output | 1 | Transfer request, active low |
| strobe | output | 1 | Double-pulse byte strobe |
| byte_hi | output | 1 | 1 = high byte on the highway, 0 = low byte |
| hw_out | output | 8 | Byte highway as driven by the block |
| hw_oe | output | 1 | Highway output enable of the block |
| tx_word_valid | output | 1 | One-cycle pulse: `tx_word` freshly captured |
| tx_word | output | 16 | Word fetched from the host |
| cwc | output | 5 | Current word count |
| hs_fail | output | 1 | One-cycle pulse on acknowledge timeout |
| ss_fault | output | 1 | Sticky subsystem fault |
| good_blk_n | output | 1 | Good-block pulse, active low |

## Verification
A stuck or mis-sequenced transfer state shows at once as a wrong request length. Every word is checked for the exact number of low request cycles, so a single lost or extra cycle in the acknowledge window or strobe sequence appears on the word where it happens. A miscounted word counter appears in the `cwc` value sampled during and right after the second strobe pulse of that word, and at the end of the message as a good-block pulse that is missing or unwanted. A corrupted byte order or capture point shows up in the bytes seen on the highway during the same word.

// File: rtl/rt_hs_pkg.sv
package rt_hs_pkg;

    localparam int HS_BYTE_W = 8;
    localparam int HS_WORD_W = 2 * HS_BYTE_W;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_REQ,
        S_XFER
    } hs_state_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_P1,
        PH_GAP,
        PH_P2,
        PH_POST
    } seq_phase_t;

    typedef struct packed {
        logic [HS_BYTE_W-1:0] hi;
        logic [HS_BYTE_W-1:0] lo;
    } hs_word_t;

    // Word count field to number of words: an all-zero field is the maximum.
    function automatic int unsigned wc_to_words(input int unsigned wc, input int unsigned wc_w);
        return (wc == 0) ? (32'd1 << wc_w) : wc;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hs_ack_timer.sv
module hs_ack_timer
    import rt_hs_pkg::*;
#(
    parameter int RX_LIMIT = 9,
    parameter int TX_LIMIT = 81
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic dir_tx,
    output logic expire
);
    localparam int MAXL = int'(max2(RX_LIMIT, TX_LIMIT));
    localparam int CW   = $clog2(MAXL + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;

    always_comb begin
        lim_m1 = dir_tx ? CW'(TX_LIMIT - 1) : CW'(RX_LIMIT - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Window closes in the last allowed request cycle.
    assign expire = run && (cnt_q == lim_m1);

endmodule

// File: rtl/hs_byte_seq.sv
module hs_byte_seq
    import rt_hs_pkg::*;
#(
    parameter int STB_W   = 2,
    parameter int STB_GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic strobe,
    output logic byte_hi,
    output logic fall_hi,
    output logic fall_lo,
    output logic done
);
    localparam int MAXC = int'(max2(STB_W, STB_GAP));
    localparam int CW   = $clog2(MAXC + 1);

    seq_phase_t    ph_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (start) ph_q <= PH_PRE;
                end
                PH_PRE: begin
                    ph_q  <= PH_P1;
                    cnt_q <= '0;
                end
                PH_P1: begin
                    if (cnt_q == CW'(STB_W - 1)) begin
                        ph_q  <= PH_GAP;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_GAP: begin
                    if (cnt_q == CW'(STB_GAP - 1)) begin
                        ph_q  <= PH_P2;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_P2: begin
                    if (cnt_q == CW'(STB_W - 1)) begin
                        ph_q  <= PH_POST;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_POST: begin
                    ph_q  <= PH_IDLE;
                    cnt_q <= '0;
                end
                default: begin
                    ph_q  <= PH_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign strobe  = (ph_q == PH_P1) || (ph_q == PH_P2);
    // The high-byte indication brackets the first pulse on both sides.
    assign byte_hi = (ph_q == PH_PRE) || (ph_q == PH_P1) ||
                     ((ph_q == PH_GAP) && (cnt_q == '0));
    assign fall_hi = (ph_q == PH_P1) && (cnt_q == CW'(STB_W - 1));
    assign fall_lo = (ph_q == PH_P2) && (cnt_q == CW'(STB_W - 1));
    assign done    = (ph_q == PH_POST);

endmodule

// File: rtl/hs_low_pulse.sv
module hs_low_pulse #(
    parameter int WIDTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic pulse_n
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (trig) begin
            cnt_q <= CW'(WIDTH);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pulse_n = (cnt_q == '0);

endmodule

// File: rtl/rt_xfer_hshake.sv
module rt_xfer_hshake
    import rt_hs_pkg::*;
#(
    parameter int WC_W       = 5,
    parameter int ACK_RX_CYC = 9,
    parameter int ACK_TX_CYC = 81,
    parameter int STB_W      = 2,
    parameter int STB_GAP    = 2,
    parameter int GBR_W      = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic                 cmd_tx,
    input  logic [WC_W-1:0]      cmd_wc,
    input  logic                 rx_word_valid,
    input  logic [HS_WORD_W-1:0] rx_word,
    input  logic                 tx_word_req,
    input  logic                 msg_end,
    input  logic                 msg_ok,
    input  logic                 host_ack_n,
    input  logic [HS_BYTE_W-1:0] hw_in,
    output logic                 new_cmd_n,
    output logic                 dir_tx,
    output logic                 req_n,
    output logic                 strobe,
    output logic                 byte_hi,
    output logic [HS_BYTE_W-1:0] hw_out,
    output logic                 hw_oe,
    output logic                 tx_word_valid,
    output logic [HS_WORD_W-1:0] tx_word,
    output logic [WC_W-1:0]      cwc,
    output logic                 hs_fail,
    output logic                 ss_fault,
    output logic                 good_blk_n
);
    localparam int CNT_W = WC_W + 1;

    hs_state_t        state_q;
    hs_word_t         hold_q;
    logic [CNT_W-1:0] target_q;
    logic [CNT_W-1:0] xfer_cnt_q;
    logic             blk_err_q;

    logic seq_start, seq_abort, fall_hi, fall_lo, seq_done;
    logic ack_expire;
    logic good_trig;
    logic count_full;

    assign count_full = (xfer_cnt_q >= target_q);
    assign seq_abort  = cmd_valid || msg_end;
    assign seq_start  = (state_q == S_REQ) && !host_ack_n && !seq_abort;

    hs_ack_timer #(
        .RX_LIMIT (ACK_RX_CYC),
        .TX_LIMIT (ACK_TX_CYC)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state_q == S_REQ),
        .dir_tx (dir_tx),
        .expire (ack_expire)
    );

    hs_byte_seq #(
        .STB_W   (STB_W),
        .STB_GAP (STB_GAP)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (seq_start),
        .abort   (seq_abort),
        .strobe  (strobe),
        .byte_hi (byte_hi),
        .fall_hi (fall_hi),
        .fall_lo (fall_lo),
        .done    (seq_done)
    );

    // Block is usable only if it is a clean, complete receive message.
    assign good_trig = msg_end && msg_ok && !cmd_valid && !dir_tx &&
                       (state_q == S_WAIT) && !blk_err_q &&
                       (xfer_cnt_q == target_q);

    hs_low_pulse #(
        .WIDTH (GBR_W)
    ) u_gbr (
        .clk     (clk),
        .rst     (rst),
        .trig    (good_trig),
        .pulse_n (good_blk_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= S_IDLE;
            hold_q        <= '0;
            target_q      <= '0;
            xfer_cnt_q    <= '0;
            blk_err_q     <= 1'b0;
            dir_tx        <= 1'b0;
            new_cmd_n     <= 1'b1;
            hs_fail       <= 1'b0;
            ss_fault      <= 1'b0;
            tx_word_valid <= 1'b0;
        end else begin
            new_cmd_n     <= !cmd_valid;
            hs_fail       <= 1'b0;
            tx_word_valid <= 1'b0;
            if (cmd_valid) begin
                state_q    <= S_WAIT;
                dir_tx     <= cmd_tx;
                target_q   <= CNT_W'(wc_to_words(32'(cmd_wc), WC_W));
                xfer_cnt_q <= '0;
                blk_err_q  <= 1'b0;
            end else if (msg_end) begin
                state_q <= S_IDLE;
            end else begin
                case (state_q)
                    S_IDLE: begin
                        state_q <= S_IDLE;
                    end
                    S_WAIT: begin
                        if (!dir_tx && rx_word_valid) begin
                            if (count_full) begin
                                blk_err_q <= 1'b1;
                            end else begin
                                hold_q  <= hs_word_t'(rx_word);
                                state_q <= S_REQ;
                            end
                        end else if (dir_tx && tx_word_req && !count_full) begin
                            state_q <= S_REQ;
                        end
                    end
                    S_REQ: begin
                        if (!dir_tx && rx_word_valid) blk_err_q <= 1'b1;
                        if (!host_ack_n) begin
                            state_q <= S_XFER;
                        end else if (ack_expire) begin
                            state_q   <= S_WAIT;
                            hs_fail   <= 1'b1;
                            ss_fault  <= 1'b1;
                            blk_err_q <= 1'b1;
                        end
                    end
                    S_XFER: begin
                        if (!dir_tx && rx_word_valid) blk_err_q <= 1'b1;
                        if (fall_hi && dir_tx) hold_q.hi <= hw_in;
                        if (fall_lo) begin
                            if (dir_tx) begin
                                hold_q.lo     <= hw_in;
                                tx_word_valid <= 1'b1;
                            end
                            xfer_cnt_q <= xfer_cnt_q + 1'b1;
                        end
                        if (seq_done) state_q <= S_WAIT;
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    assign req_n   = !((state_q == S_REQ) || (state_q == S_XFER));
    assign hw_oe   = (state_q == S_XFER) && !dir_tx;
    assign hw_out  = byte_hi ? hold_q.hi : hold_q.lo;
    assign tx_word = hold_q;
    assign cwc     = xfer_cnt_q[WC_W-1:0];

endmodule

// File: rtl/hs_checker.sv
module hs_checker #(
    parameter int WC_W = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            new_cmd_n,
    input logic            dir_tx,
    input logic            req_n,
    input logic            strobe,
    input logic            hw_oe,
    input logic            tx_word_valid,
    input logic [WC_W-1:0] cwc,
    input logic            hs_fail,
    input logic            ss_fault,
    input logic            good_blk_n
);
    // R1: new-command pulse is exactly one cycle wide
    assert_nbgt_width_R1: assert property (@(posedge clk) disable iff (rst)
        !new_cmd_n |=> new_cmd_n);

    // R3: the block drives the highway only in receive messages
    assert_oe_dir_R3: assert property (@(posedge clk) disable iff (rst)
        hw_oe |-> !dir_tx);

    // R6: strobes occur only under an active request
    assert_stb_req_R6: assert property (@(posedge clk) disable iff (rst)
        strobe |-> !req_n);

    // R4: captured word is flagged outside the strobe pulses, in transmit only
    assert_txv_dir_R4: assert property (@(posedge clk) disable iff (rst)
        tx_word_valid |-> (dir_tx && !strobe));

    // R5: the word counter only steps by one or clears
    assert_cwc_step_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(cwc) |-> ((cwc == WC_W'($past(cwc) + 1'b1)) || (cwc == '0)));

    // R7: a timeout releases the request and raises the fault together
    assert_fail_release_R7: assert property (@(posedge clk) disable iff (rst)
        hs_fail |-> (req_n && ss_fault));

    // R8: handshake failure is a single-cycle pulse
    assert_fail_single_R8: assert property (@(posedge clk) disable iff (rst)
        hs_fail |=> !hs_fail);

    // R9: the subsystem fault is sticky
    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ss_fault |=> ss_fault);

    // R10: a good-block pulse only starts in a receive message
    assert_gbr_rx_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(good_blk_n) |-> !dir_tx);

endmodule

bind rt_xfer_hshake hs_checker #(.WC_W(WC_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .new_cmd_n     (new_cmd_n),
    .dir_tx        (dir_tx),
    .req_n         (req_n),
    .strobe        (strobe),
    .hw_oe         (hw_oe),
    .tx_word_valid (tx_word_valid),
    .cwc           (cwc),
    .hs_fail       (hs_fail),
    .ss_fault      (ss_fault),
    .good_blk_n    (good_blk_n)
);

// File: tb/sim_rt_xfer_hshake.sv
module sim_rt_xfer_hshake;
    localparam int CLK_PERIOD = 10;
    localparam int RX_LIM = 9;
    localparam int TX_LIM = 81;
    localparam int XFER_CYC = 8;   // setup + pulse + gap + pulse + release

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0, cmd_tx = 1'b0;
    logic [4:0]  cmd_wc = '0;
    logic        rx_word_valid = 1'b0;
    logic [15:0] rx_word = '0;
    logic        tx_word_req = 1'b0;
    logic        msg_end = 1'b0, msg_ok = 1'b0;
    logic        host_ack_n = 1'b1;
    logic [15:0] host_data = '0;
    logic [7:0]  hw_in;
    logic        new_cmd_n, dir_tx, req_n, strobe, byte_hi, hw_oe;
    logic [7:0]  hw_out;
    logic        tx_word_valid;
    logic [15:0] tx_word;
    logic [4:0]  cwc;
    logic        hs_fail, ss_fault, good_blk_n;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // per-word observations
    int r_pulses, r_gap, r_reqlow, r_txv, r_cwc2, r_cwcpost;
    int r_w[2];
    bit r_bad_bi, r_bad_dat, r_oe_bad, r_fail;
    logic [15:0] r_txword;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign hw_in = byte_hi ? host_data[15:8] : host_data[7:0];

    rt_xfer_hshake u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_tx(cmd_tx), .cmd_wc(cmd_wc),
        .rx_word_valid(rx_word_valid), .rx_word(rx_word), .tx_word_req(tx_word_req),
        .msg_end(msg_end), .msg_ok(msg_ok), .host_ack_n(host_ack_n), .hw_in(hw_in),
        .new_cmd_n(new_cmd_n), .dir_tx(dir_tx), .req_n(req_n), .strobe(strobe),
        .byte_hi(byte_hi), .hw_out(hw_out), .hw_oe(hw_oe), .tx_word_valid(tx_word_valid),
        .tx_word(tx_word), .cwc(cwc), .hs_fail(hs_fail), .ss_fault(ss_fault),
        .good_blk_n(good_blk_n)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic start_cmd(input logic tx, input logic [4:0] wc);
        cmd_valid = 1'b1; cmd_tx = tx; cmd_wc = wc;
        @(negedge clk);
        cmd_valid = 1'b0;
        check_eq("R1 new_cmd_n low", int'(new_cmd_n), 0);
        check_eq("R1 dir_tx", int'(dir_tx), int'(tx));
        check_eq("R1 cwc cleared", int'(cwc), 0);
        @(negedge clk);
        check_eq("R1 new_cmd_n one cycle", int'(new_cmd_n), 1);
    endtask

    // Host side: answer the request after ack_dly request cycles and watch the transfer.
    task automatic host_xfer(input int ack_dly, input logic [15:0] data);
        int guard;
        logic prev;
        host_data = data;
        r_pulses = 0; r_w[0] = 0; r_w[1] = 0; r_gap = 0; r_reqlow = 0; r_txv = 0;
        r_cwc2 = -1; r_cwcpost = -1; r_bad_bi = 0; r_bad_dat = 0; r_oe_bad = 0;
        r_txword = '0;
        prev = 1'b0; guard = 0;
        while (req_n == 1'b0 && guard < 400) begin
            r_reqlow++; guard++;
            if (r_reqlow - 1 == ack_dly) host_ack_n = 1'b0;
            if (strobe && !prev) r_pulses++;
            if (strobe) begin
                if (r_pulses >= 1 && r_pulses <= 2) r_w[r_pulses-1]++;
                if (byte_hi != (r_pulses == 1)) r_bad_bi = 1;
                if (!dir_tx && (hw_oe !== 1'b1 ||
                    hw_out !== ((r_pulses == 1) ? data[15:8] : data[7:0]))) r_bad_dat = 1;
                if (r_pulses == 2) r_cwc2 = int'(cwc);
            end else begin
                if (r_pulses == 1) r_gap++;
                if (prev && r_pulses == 2) r_cwcpost = int'(cwc);
            end
            if (dir_tx && hw_oe) r_oe_bad = 1;
            if (tx_word_valid) begin r_txv++; r_txword = tx_word; end
            prev = strobe;
            @(negedge clk);
        end
        r_fail = hs_fail;
        host_ack_n = 1'b1;
    endtask

    task automatic rx_trigger(input logic [15:0] d);
        rx_word_valid = 1'b1; rx_word = d;
        @(negedge clk);
        rx_word_valid = 1'b0;
    endtask

    task automatic tx_trigger();
        tx_word_req = 1'b1;
        @(negedge clk);
        tx_word_req = 1'b0;
    endtask

    // Full check of one accepted word; k = words already transferred in this message.
    task automatic word_ok(input logic tx, input int ack_dly, input logic [15:0] d, input int k);
        if (tx) tx_trigger(); else rx_trigger(d);
        check_eq("R2 request raised", int'(req_n), 0);
        host_xfer(ack_dly, d);
        check_eq("R3 two strobe pulses", r_pulses, 2);
        check_eq("R3 first pulse width", r_w[0], 2);
        check_eq("R3 second pulse width", r_w[1], 2);
        check_eq("R3 pulse gap", r_gap, 2);
        check_eq("R3 byte indicator", int'(r_bad_bi), 0);
        check_eq("R3 highway drive", int'(r_bad_dat | r_oe_bad), 0);
        check_eq("R5 cwc during second pulse", r_cwc2, k % 32);
        check_eq("R5 cwc after second pulse", r_cwcpost, (k + 1) % 32);
        check_eq("R6 request length", r_reqlow, ack_dly + 1 + XFER_CYC);
        check_eq("R7 no failure on timely ack", int'(r_fail), 0);
        if (tx) begin
            check_eq("R4 tx_word_valid count", r_txv, 1);
            check_eq("R4 tx_word", int'(r_txword), int'(d));
        end
    endtask

    task automatic end_msg(input logic ok, input int exp_lows, input string tag);
        int lows;
        msg_end = 1'b1; msg_ok = ok;
        @(negedge clk);
        msg_end = 1'b0; msg_ok = 1'b0;
        lows = 0;
        repeat (8) begin
            if (!good_blk_n) lows++;
            @(negedge clk);
        end
        check_eq(tag, lows, exp_lows);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        do_reset();
        // R13 reset state
        check_eq("R13 req_n", int'(req_n), 1);
        check_eq("R13 new_cmd_n", int'(new_cmd_n), 1);
        check_eq("R13 good_blk_n", int'(good_blk_n), 1);
        check_eq("R13 strobe", int'(strobe), 0);
        check_eq("R13 hw_oe", int'(hw_oe), 0);
        check_eq("R13 hs_fail", int'(hs_fail), 0);
        check_eq("R13 ss_fault", int'(ss_fault), 0);
        check_eq("R13 tx_word_valid", int'(tx_word_valid), 0);
        check_eq("R13 dir_tx", int'(dir_tx), 0);
        check_eq("R13 cwc", int'(cwc), 0);

        // Receive sweep over every word count, ack delays 0..8 (R7 window edge included)
        for (int wc = 0; wc < 32; wc++) begin
            int n;
            n = (wc == 0) ? 32 : wc;
            start_cmd(1'b0, 5'(wc));
            for (int k = 0; k < n; k++)
                word_ok(1'b0, k % RX_LIM, 16'(16'hA55A ^ (wc * 37 + k * 1021)), k);
            end_msg(1'b1, 3, "R10 good block after full receive");
        end

        // Transmit sweep, ack delays up to 80 (R8 window edge included)
        for (int wc = 1; wc <= 32; wc++) begin
            start_cmd(1'b1, 5'(wc));
            for (int k = 0; k < wc; k++)
                word_ok(1'b1, (k == 0) ? (TX_LIM - 1) : ((k * 13) % TX_LIM),
                        16'(16'h3C96 + wc * 257 + k * 4099), k);
            end_msg(1'b1, 0, "R11 no good block for transmit");
        end

        // R7 receive timeout
        start_cmd(1'b0, 5'd2);
        word_ok(1'b0, 3, 16'h1234, 0);
        rx_trigger(16'h5678);
        host_xfer(RX_LIM, 16'h5678);
        check_eq("R7 request length on timeout", r_reqlow, RX_LIM);
        check_eq("R7 hs_fail pulse", int'(r_fail), 1);
        check_eq("R7 no strobe on timeout", r_pulses, 0);
        check_eq("R7 ss_fault set", int'(ss_fault), 1);
        @(negedge clk);
        check_eq("R7 hs_fail one cycle", int'(hs_fail), 0);
        end_msg(1'b1, 0, "R11 no good block after timeout");

        // R8 transmit timeout, R9 stickiness
        start_cmd(1'b1, 5'd1);
        tx_trigger();
        host_xfer(TX_LIM, 16'hBEEF);
        check_eq("R8 request length on timeout", r_reqlow, TX_LIM);
        check_eq("R8 hs_fail pulse", int'(r_fail), 1);
        end_msg(1'b1, 0, "R11 transmit end");
        start_cmd(1'b0, 5'd1);
        check_eq("R9 fault survives new command", int'(ss_fault), 1);
        do_reset();
        check_eq("R9 fault cleared by reset", int'(ss_fault), 0);

        // R11 short count and message not ok
        start_cmd(1'b0, 5'd3);
        word_ok(1'b0, 0, 16'h0F0F, 0);
        word_ok(1'b0, 1, 16'hF0F0, 1);
        end_msg(1'b1, 0, "R11 short count");
        start_cmd(1'b0, 5'd1);
        word_ok(1'b0, 2, 16'hAA55, 0);
        end_msg(1'b0, 0, "R11 msg_ok low");

        // R12 excess word
        start_cmd(1'b0, 5'd1);
        word_ok(1'b0, 0, 16'h8001, 0);
        rx_trigger(16'h7FFE);
        begin
            int lowseen;
            lowseen = 0;
            repeat (4) begin
                if (!req_n) lowseen++;
                @(negedge clk);
            end
            check_eq("R12 no request for excess word", lowseen, 0);
        end
        check_eq("R12 cwc unchanged", int'(cwc), 1);
        end_msg(1'b1, 0, "R12 excess word spoils block");

        // R11 preemption during a strobe sequence
        start_cmd(1'b0, 5'd4);
        word_ok(1'b0, 0, 16'h1111, 0);
        rx_trigger(16'h2222);
        host_ack_n = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R11 strobe active before preempt", int'(strobe), 1);
        cmd_valid = 1'b1; cmd_tx = 1'b0; cmd_wc = 5'd1;
        @(negedge clk);
        cmd_valid = 1'b0; host_ack_n = 1'b1;
        check_eq("R11 preempt drops request", int'(req_n), 1);
        check_eq("R11 preempt stops strobe", int'(strobe), 0);
        check_eq("R1 preempt new_cmd_n", int'(new_cmd_n), 0);
        check_eq("R1 preempt clears cwc", int'(cwc), 0);
        @(negedge clk);
        end_msg(1'b1, 0, "R11 preempted block");

        // Recovery: clean block after all of the above
        start_cmd(1'b0, 5'd2);
        word_ok(1'b0, 8, 16'hAA55, 0);
        word_ok(1'b0, 0, 16'h55AA, 1);
        end_msg(1'b1, 3, "R10 good block after recovery");

        finished = 1;
        report();
    end
endmodule